// File: doc/BRIEF.md
# Data-Triggered Cluster Sleep Controller

This controller governs the power state of one cluster of processing elements in a statically scheduled array. When the cluster's program reports that it has nothing to do, the controller withdraws the processor enable and asks the power logic for a light or a deep low-power state. The cluster's routing switches are never gated, so traffic keeps passing through it while it sleeps.

Any arriving data word, control token or completion strobe from an external transfer wakes the cluster with no host involvement. The controller then waits out a wake latency that depends on how deep the sleep was. Next it holds a fetch-prefill window so the instruction streams can refill. Finally it keeps the processors halted until the global schedule slot counter reaches a programmed resume slot. This lands the cluster back in lock-step with its neighbours rather than letting it carry on from where it stopped. A program that has started an external transfer can request sleep again and rely on the transfer-done strobe to bring it back.

Top module: `cluster_nap_ctrl`

## Requirements
- R1: After reset the cluster is running: `ready_o`=1, `pe_en_o`=1, `gate_req_o`=0, `gate_deep_o`=0, `prefill_en_o`=0.
- R2: An idle request while running, with no wake event in the same cycle, drops `pe_en_o` and `ready_o` on the next cycle (one entry cycle with `gate_req_o`=0). On the cycle after that `gate_req_o` rises, with `gate_deep_o` equal to `deep_sel_i` as sampled together with the idle request (1 = deep, 0 = light).
- R3: An idle request in the same cycle as a wake event while running is ignored: the cluster stays running.
- R4: While sleeping, a pulse on any one of `data_arrive_i`, `ctrl_arrive_i` or `xfer_done_i` makes `gate_req_o` fall on the next cycle.
- R5: The wake wait lasts exactly DEEP_WAKE cycles after deep sleep and LIGHT_WAKE cycles after light sleep. During it `pe_en_o`, `gate_req_o`, `prefill_en_o` and `ready_o` are all 0.
- R6: A wake event during the entry cycle aborts entry: `gate_req_o` never rises, and the wake wait takes LIGHT_WAKE cycles.
- R7: After the wake wait, `prefill_en_o` is high for exactly PREFILL_CYC consecutive cycles.
- R8: After prefill, `pe_en_o` stays low until the cycle in which `slot_i` equals `resume_slot_i`. `pe_en_o` is 1 in that cycle, and `ready_o` is 1 from the next cycle on. The slot counter may wrap before the match.
- R9: `sw_en_o` (routing switch enable) is 1 in every cycle, in every state.
- R10: Wake events and idle requests during the wake wait and the prefill window do not change their lengths.
- R11: With no wake event, the sleep state and its `gate_req_o`/`gate_deep_o` values hold indefinitely, even while idle stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_arrive_i | input | 1 | Data word arrived for the cluster |
| ctrl_arrive_i | input | 1 | Control token arrived |
| xfer_done_i | input | 1 | External transfer completed |
| idle_req_i | input | 1 | Program requests sleep |
| deep_sel_i | input | 1 | Sleep depth: 1 deep, 0 light |
| slot_i | input | SLOT_W | Global schedule slot counter |
| resume_slot_i | input | SLOT_W | Slot at which processors restart |
| pe_en_o | output | 1 | Processor enable |
| gate_req_o | output | 1 | Clock/power gate request |
| gate_deep_o | output | 1 | Requested gating is deep |
| prefill_en_o | output | 1 | Instruction fetch prefill enable |
| ready_o | output | 1 | Cluster is running in schedule |
| sw_en_o | output | 1 | Routing switch enable, never dropped |

## Verification
The bench builds the controller with a 4-bit slot counter, a deep wake latency of 5, a light latency of 2 and a prefill window of 3. The short latencies keep every phase only a few cycles long. The 16-slot counter makes wraparound before the resume slot occur within a single alignment. The distinct latencies let each test tell a deep wake from a light one and an aborted entry from a completed one by counting cycles at the ports.

// File: rtl/nap_pkg.sv
package nap_pkg;

  typedef enum logic [2:0] {
    NS_ACTIVE  = 3'd0,
    NS_ENTER   = 3'd1,
    NS_SLEEP_L = 3'd2,
    NS_SLEEP_D = 3'd3,
    NS_WAKING  = 3'd4,
    NS_PREFILL = 3'd5,
    NS_ALIGN   = 3'd6
  } nap_state_t;

  // cycles of wake wait minus one, to be loaded into the down counter
  function automatic int wake_load(input logic deep, input int light_lat, input int deep_lat);
    return deep ? (deep_lat - 1) : (light_lat - 1);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nap_event_merge.sv
module nap_event_merge (
  input  logic data_arrive_i,
  input  logic ctrl_arrive_i,
  input  logic xfer_done_i,
  output logic wake_any_o
);
  // R4: every source is an equal wake event
  assign wake_any_o = data_arrive_i | ctrl_arrive_i | xfer_done_i;
endmodule

// File: rtl/nap_timer.sv
module nap_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/nap_fsm.sv
module nap_fsm
  import nap_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int LIGHT_WAKE  = 2,
  parameter int DEEP_WAKE   = 8,
  parameter int PREFILL_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_any_i,
  input  logic             idle_req_i,
  input  logic             deep_sel_i,
  input  logic             slot_hit_i,
  input  logic             timer_done_i,
  output logic             timer_load_o,
  output logic [CNT_W-1:0] timer_val_o,
  output nap_state_t       state_o
);
  nap_state_t st_q, st_d;
  logic       depth_q;

  always_comb begin
    st_d         = st_q;
    timer_load_o = 1'b0;
    timer_val_o  = '0;
    unique case (st_q)
      NS_ACTIVE:  if (idle_req_i && !wake_any_i) st_d = NS_ENTER;       // R2 R3
      NS_ENTER: begin
        if (wake_any_i) begin                                           // R6
          st_d         = NS_WAKING;
          timer_load_o = 1'b1;
          timer_val_o  = CNT_W'(wake_load(1'b0, LIGHT_WAKE, DEEP_WAKE));
        end else begin
          st_d = depth_q ? NS_SLEEP_D : NS_SLEEP_L;
        end
      end
      NS_SLEEP_L, NS_SLEEP_D: begin
        if (wake_any_i) begin                                           // R4 R5
          st_d         = NS_WAKING;
          timer_load_o = 1'b1;
          timer_val_o  = CNT_W'(wake_load(st_q == NS_SLEEP_D, LIGHT_WAKE, DEEP_WAKE));
        end
      end
      NS_WAKING: begin
        if (timer_done_i) begin                                         // R7
          st_d         = NS_PREFILL;
          timer_load_o = 1'b1;
          timer_val_o  = CNT_W'(PREFILL_CYC - 1);
        end
      end
      NS_PREFILL: if (timer_done_i) st_d = NS_ALIGN;
      NS_ALIGN:   if (slot_hit_i)   st_d = NS_ACTIVE;                   // R8
      default:    st_d = NS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= NS_ACTIVE;
      depth_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == NS_ACTIVE && idle_req_i) depth_q <= deep_sel_i;
    end
  end

  assign state_o = st_q;

  // R11: a sleep state with no wake event stays unchanged
  assert_sleep_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == NS_SLEEP_L || st_q == NS_SLEEP_D) && !wake_any_i) |=> $stable(st_q));
endmodule

// File: rtl/cluster_nap_ctrl.sv
module cluster_nap_ctrl
  import nap_pkg::*;
#(
  parameter int SLOT_W      = 6,
  parameter int LIGHT_WAKE  = 2,
  parameter int DEEP_WAKE   = 8,
  parameter int PREFILL_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_arrive_i,
  input  logic              ctrl_arrive_i,
  input  logic              xfer_done_i,
  input  logic              idle_req_i,
  input  logic              deep_sel_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] resume_slot_i,
  output logic              pe_en_o,
  output logic              gate_req_o,
  output logic              gate_deep_o,
  output logic              prefill_en_o,
  output logic              ready_o,
  output logic              sw_en_o
);
  localparam int MAX_CNT = max3(LIGHT_WAKE, DEEP_WAKE, PREFILL_CYC);
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic             wake_any;
  logic             slot_hit;
  logic             timer_done;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  nap_state_t       state;

  nap_event_merge u_merge (
    .data_arrive_i (data_arrive_i),
    .ctrl_arrive_i (ctrl_arrive_i),
    .xfer_done_i   (xfer_done_i),
    .wake_any_o    (wake_any)
  );

  nap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (timer_load),
    .load_val_i (timer_val),
    .done_o     (timer_done)
  );

  assign slot_hit = (slot_i == resume_slot_i);

  nap_fsm #(
    .CNT_W       (CNT_W),
    .LIGHT_WAKE  (LIGHT_WAKE),
    .DEEP_WAKE   (DEEP_WAKE),
    .PREFILL_CYC (PREFILL_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .wake_any_i   (wake_any),
    .idle_req_i   (idle_req_i),
    .deep_sel_i   (deep_sel_i),
    .slot_hit_i   (slot_hit),
    .timer_done_i (timer_done),
    .timer_load_o (timer_load),
    .timer_val_o  (timer_val),
    .state_o      (state)
  );

  assign ready_o      = (state == NS_ACTIVE);
  assign pe_en_o      = ready_o || (state == NS_ALIGN && slot_hit);   // R8
  assign gate_req_o   = (state == NS_SLEEP_L) || (state == NS_SLEEP_D);
  assign gate_deep_o  = (state == NS_SLEEP_D);
  assign prefill_en_o = (state == NS_PREFILL);
  assign sw_en_o      = 1'b1;                                         // R9

  assert_gate_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gate_req_o |-> (!pe_en_o && !prefill_en_o && !ready_o));

  assert_wake_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_req_o && wake_any) |=> !gate_req_o);

  assert_coincident_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && idle_req_i && wake_any) |=> ready_o);

  assert_prefill_after_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prefill_en_o) |-> $past(timer_done));

  assert_align_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_en_o && !ready_o) |-> (slot_i == resume_slot_i));

  assert_ready_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(pe_en_o));
endmodule

// File: tb/tb_cluster_nap_ctrl.sv
`timescale 1ns/1ps
module tb_cluster_nap_ctrl;
  localparam int SW = 4, LW = 2, DW = 5, PF = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic data_a = 0, ctrl_a = 0, xfer_d = 0, idle = 0, deep = 0;
  logic [SW-1:0] slot = '0, resume = '0;
  logic pe_en, gate, gdeep, prefill, ready, sw_en;
  int checks = 0, errors = 0;
  logic noise = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) slot <= slot + 1'b1;

  cluster_nap_ctrl #(.SLOT_W(SW), .LIGHT_WAKE(LW), .DEEP_WAKE(DW), .PREFILL_CYC(PF)) dut (
    .clk(clk), .rst_n(rst_n), .data_arrive_i(data_a), .ctrl_arrive_i(ctrl_a),
    .xfer_done_i(xfer_d), .idle_req_i(idle), .deep_sel_i(deep), .slot_i(slot),
    .resume_slot_i(resume), .pe_en_o(pe_en), .gate_req_o(gate), .gate_deep_o(gdeep),
    .prefill_en_o(prefill), .ready_o(ready), .sw_en_o(sw_en));

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // drive one wake source for one cycle; leaves the sample at the first waking cycle
  task automatic pulse(input int which);
    @(negedge clk);
    data_a = (which == 0); ctrl_a = (which == 1); xfer_d = (which == 2);
    #1;
    @(negedge clk);
    data_a = 0; ctrl_a = 0; xfer_d = 0;
    #1;
  endtask

  task automatic go_sleep(input logic d);
    @(negedge clk); idle = 1; deep = d; #1;
    step(); idle = 0;
    chk(ready, 0, "R2 ready low in entry");
    chk(gate, 0, "R2 no gate in entry");
    step();
    chk(gate, 1, "R2 gate_req raised");
    chk(gdeep, d, "R2 gate_deep matches depth");
  endtask

  // measures wake wait, prefill and alignment from the current sample
  task automatic wake_seq(input int exp_lat, input string tag);
    int n = 0, m = 0, a = 0;
    logic [SW-1:0] first;
    while (!prefill && !ready && n < 50) begin
      if (pe_en || gate) chk(1, 0, {tag, " R5 outputs low in wake wait"});
      n++;
      @(negedge clk); idle = noise; data_a = noise; #1;
    end
    chk(n, exp_lat, {tag, " R5 wake wait length"});
    while (prefill && m < 50) begin
      m++;
      @(negedge clk); idle = noise; data_a = noise; #1;
    end
    idle = 0; data_a = 0;
    chk(m, PF, {tag, " R7 prefill length"});
    first = slot;
    while (!pe_en && a < 40) begin
      if (ready) chk(1, 0, {tag, " R8 ready before slot match"});
      a++;
      step();
    end
    chk(slot, resume, {tag, " R8 pe_en at resume slot"});
    chk(a, int'(SW'(resume - first)), {tag, " R8 wait to resume slot incl wrap"});
    step();
    chk(ready, 1, {tag, " R8 ready after alignment"});
  endtask

  task automatic t_reset();
    chk(ready, 1, "R1 ready"); chk(pe_en, 1, "R1 pe_en");
    chk(gate, 0, "R1 gate"); chk(gdeep, 0, "R1 gate_deep");
    chk(prefill, 0, "R1 prefill"); chk(sw_en, 1, "R9 switch enable at reset");
  endtask

  task automatic t_deep_data();
    resume = 4'd9;
    go_sleep(1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); idle = 1; #1;
      if (!gate || !gdeep) chk(gate + gdeep, 2, "R11 deep sleep held");
      chk(sw_en, 1, "R9 switch enable asleep");
    end
    idle = 0;
    pulse(0);
    chk(gate, 0, "R4 gate falls after data");
    wake_seq(DW, "deep/data");
  endtask

  task automatic t_light_ctrl();
    resume = 4'd2;
    go_sleep(0);
    pulse(1);
    chk(gate, 0, "R4 gate falls after control token");
    wake_seq(LW, "light/ctrl");
  endtask

  task automatic t_xfer();
    resume = 4'd15;
    go_sleep(1);
    pulse(2);
    chk(gate, 0, "R4 gate falls after transfer done");
    wake_seq(DW, "deep/xfer");
  endtask

  task automatic t_coincident();
    @(negedge clk); idle = 1; deep = 1; data_a = 1; #1;
    step(); idle = 0; data_a = 0;
    chk(ready, 1, "R3 idle with wake ignored");
    chk(pe_en, 1, "R3 pe_en kept");
    step();
    chk(gate, 0, "R3 no gate after coincident");
  endtask

  task automatic t_abort();
    resume = 4'd6;
    @(negedge clk); idle = 1; deep = 1; #1;
    @(negedge clk); idle = 0; ctrl_a = 1; #1;
    chk(ready, 0, "R6 in entry cycle");
    @(negedge clk); ctrl_a = 0; #1;
    chk(gate, 0, "R6 gate never raised");
    wake_seq(LW, "abort");
  endtask

  task automatic t_noise();
    resume = 4'd0;
    go_sleep(1);
    noise = 1;
    pulse(0);
    wake_seq(DW, "R10 noise");
    noise = 0;
  endtask

  initial begin
    fork
      begin
        #3 rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1; #1;
        t_reset();
        t_deep_data();
        t_light_ctrl();
        t_xfer();
        t_coincident();
        t_abort();
        t_noise();
        chk(sw_en, 1, "R9 switch enable at end");
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule